// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

A three-bit counter that walks a fixed, non-binary loop of five codes, one step per enabled clock: 000, 010, 011, 101, 110, then back to 000. The bits are named C, B, A from the most significant down. The next-state equations are C+ = A, B+ = not B or (not A and not C), and A+ = B and not C.

The three codes outside the loop are given fixed successors, so the counter leads itself back into the loop whatever value it powers up with. Code 001 jumps to 110. Code 100 jumps to 010. Code 111 jumps to 100, which reaches 010 on the following step.

A synchronous reset clears the counter, and a low enable freezes it. A load port, meant only for test, forces any three-bit value so that each recovery path can be checked. A parameter can remove the load port's effect.

Top module: `seq5_counter`

## Requirements
- R1: When rst is high at a rising clock edge, q becomes 000 after that edge, whatever en, ld and ld_val hold.
- R2: With en high, ld low and rst low, a q in the loop advances 000→010→011→101→110→000, one step per edge.
- R3: With en low, ld low and rst low, q keeps its value across the edge.
- R4: With ld high and rst low, q takes ld_val after the edge, whatever en holds (only when the load parameter is enabled).
- R5: With en high, ld and rst low, code 001 steps to 110.
- R6: With en high, ld and rst low, code 100 steps to 010.
- R7: With en high, ld and rst low, code 111 steps to 100.
- R8: From any of the eight codes, after at most two enabled steps q is one of 000, 010, 011, 101, 110, and it stays in that set from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to 000, highest priority |
| en | input | 1 | Step enable |
| ld | input | 1 | Test load strobe, above enable and below reset |
| ld_val | input | 3 | Value forced by ld, bit 2 = C, bit 0 = A |
| q | output | 3 | Counter state, bit 2 = C, bit 1 = B, bit 0 = A |

## Verification
The bench builds the counter with the load hook enabled (HAS_LOAD = 1). Only with this setting can the three illegal codes be placed in the register on purpose, so the recovery path of each code can be driven and checked. A behavioural model steps through a list of the loop's codes and a separate map of the illegal codes. It is compared with q on every clock while enable, hold, load, and reset in the middle of a run are mixed. Each of the eight codes is also loaded and stepped twice to confirm that it settles into the loop.

// File: rtl/seq5_counter.sv
module seq5_counter #(
  parameter bit HAS_LOAD = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ld,
  input  logic [2:0] ld_val,
  output logic [2:0] q
);

  logic       c, b, a;
  logic       ld_eff;
  logic [2:0] nxt;

  assign {c, b, a} = q;
  assign nxt = {a, ~b | (~a & ~c), b & ~c};

  generate
    if (HAS_LOAD) begin : g_load
      assign ld_eff = ld;
    end else begin : g_noload
      assign ld_eff = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         q <= 3'b000;
    else if (ld_eff) q <= ld_val;
    else if (en)     q <= nxt;
  end

  function automatic logic in_loop(input logic [2:0] v);
    return v == 3'b000 || v == 3'b010 || v == 3'b011 || v == 3'b101 || v == 3'b110;
  endfunction

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_eff && !en) |=> $stable(q));

  // R2
  loop_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_eff && in_loop(q)) |=> in_loop(q));

  // R5
  from_001_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_eff && q == 3'b001) |=> q == 3'b110);

  // R6
  from_100_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_eff && q == 3'b100) |=> q == 3'b010);

  // R7
  from_111_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_eff && q == 3'b111) |=> q == 3'b100);

  generate
    if (HAS_LOAD) begin : g_load_chk
      // R4
      load_take_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> q == $past(ld_val));
    end
  endgenerate

endmodule

// File: tb/tb_seq5_counter.sv
module tb_seq5_counter;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       ld = 1'b0;
  logic [2:0] ld_val = 3'b000;
  logic [2:0] q;

  int checks = 0;
  int errors = 0;
  int model = 0;
  int loop_q[$] = '{0, 2, 3, 5, 6};

  seq5_counter #(.HAS_LOAD(1'b1)) dut (
    .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val), .q(q)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic bit is_loop(int v);
    foreach (loop_q[i]) if (loop_q[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int succ(int v);
    foreach (loop_q[i]) if (loop_q[i] == v) return loop_q[(i + 1) % 5];
    case (v)
      1: return 6;
      4: return 2;
      7: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (int'(q) !== exp) begin
      errors++;
      $display("FAIL %s q=%0d expected %0d", tag, q, exp);
    end
  endtask

  task automatic step(string tag, bit r, bit l, int v, bit e);
    rst = r; ld = l; ld_val = 3'(v); en = e;
    @(posedge clk);
    if (r) model = 0;
    else if (l) model = v;
    else if (e) model = succ(model);
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1 reset", 1, 0, 0, 1);
    step("R1 reset with load", 1, 1, 7, 1);
    for (int k = 0; k < 12; k++) step("R2 loop order", 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) step("R3 hold", 0, 0, 0, 0);
    step("R2 after hold", 0, 0, 0, 1);
    step("R4 load en low", 0, 1, 5, 0);
    step("R4 load en high", 0, 1, 3, 1);
    step("R2 from loaded", 0, 0, 0, 1);
    step("R5 load 001", 0, 1, 1, 0);
    step("R5 001 to 110", 0, 0, 0, 1);
    step("R6 load 100", 0, 1, 4, 0);
    step("R3 hold illegal", 0, 0, 0, 0);
    step("R6 100 to 010", 0, 0, 0, 1);
    step("R7 load 111", 0, 1, 7, 1);
    step("R7 111 to 100", 0, 0, 0, 1);
    step("R6 then 010", 0, 0, 0, 1);
    step("R1 reset mid run", 1, 0, 0, 1);
    for (int c = 0; c < 8; c++) begin
      step("R4 load code", 0, 1, c, 0);
      step("R8 step one", 0, 0, 0, 1);
      step("R8 step two", 0, 0, 0, 1);
      checks++;
      if (!is_loop(int'(q))) begin
        errors++;
        $display("FAIL R8 start %0d q=%0d expected a loop code", c, q);
      end
      for (int k = 0; k < 5; k++) begin
        step("R8 stays", 0, 0, 0, (k % 2) == 0);
        checks++;
        if (!is_loop(int'(q))) begin
          errors++;
          $display("FAIL R8 left loop q=%0d expected a loop code", q);
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule